// File: doc/BRIEF.md
# Paired-Page TLB Lookup

This block is a fully associative translation buffer for 32-bit virtual addresses. Each of its entries describes two neighbouring virtual pages, an even one and an odd one, that share one virtual tag, one address-space identifier and one page-size mask. Each half has its own physical frame number, valid bit and dirty bit. A caller presents a virtual address, the current address-space identifier and a read/write flag. One cycle later the block returns an outcome code, a physical address and a writable flag.

Entries are loaded through a single indexed write port. All entries are compared in parallel. When several entries claim the same address, the entry with the lowest index is used. The block only classifies the access. Deciding which entry to replace, and what the processor does with a miss or a permission failure, is left to the logic around it.

Top module: `tlbp_top`

## Requirements
- R1: A lookup request accepted on a clock edge sets `res_valid` high for exactly the next cycle, with its results registered at that same edge. While `lk_req` is low, `res_code`, `res_pa` and `res_writable` keep their last values and `res_valid` is low.
- R2: An entry hits when its virtual page-pair number equals the address bits [31:13], comparing only the bits not covered by the entry's page mask. In addition, either the entry's global flag must be set or its 8-bit ASID must equal `lk_asid`.
- R3: Address bits [12:0] are never compared. A set page-mask bit n also excludes address bit 13+n from the comparison, so a mask of 0 covers an 8 KB pair and a mask of 3 covers a 32 KB pair.
- R4: The odd half is selected when the address bit just above the single-page offset is 1, and the even half is selected otherwise. That bit is bit 12 for mask 0 and bit 14 for mask 3.
- R5: A hit whose selected half has its valid bit clear returns code 2 (INVALID) with `res_pa` = 0.
- R6: A write (`lk_write`=1) to a valid half whose dirty bit is clear returns code 3 (MODIFIED) with `res_pa` = 0. A read, or a write to a valid dirty half, returns code 0 (MATCH).
- R7: On MATCH, `res_pa` equals the selected frame number shifted left by 12, ORed with the address bits that lie below the odd/even select bit.
- R8: When no entry hits, the code is 1 (NOMATCH), `res_writable` is 0 and `res_pa` is 0.
- R9: On any hit (MATCH, INVALID or MODIFIED), `res_writable` equals the selected half's dirty bit.
- R10: When more than one entry hits, the lowest-index hitting entry alone decides the result, even if its selected half is invalid.
- R11: An entry write takes effect at the clock edge that samples `wr_en`. A lookup sampled at that same edge still sees the entry's previous contents.
- R12: Synchronous reset clears `res_valid`, sets the code to NOMATCH and clears every entry field (tag, mask, ASID, global flag, frames, valid and dirty bits). After reset, a lookup with a non-zero ASID therefore misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load the entry at `wr_idx` |
| wr_idx | input | 4 | Entry index to load |
| wr_vpn2 | input | 19 | Virtual page-pair number (address bits 31:13) |
| wr_pmask | input | 19 | Page-size mask aligned with `wr_vpn2` |
| wr_asid | input | 8 | Entry address-space identifier |
| wr_global | input | 1 | Entry matches any ASID |
| wr_pfn_even | input | 20 | Frame number of the even half |
| wr_pfn_odd | input | 20 | Frame number of the odd half |
| wr_v_even | input | 1 | Even half valid |
| wr_v_odd | input | 1 | Odd half valid |
| wr_d_even | input | 1 | Even half dirty (writable) |
| wr_d_odd | input | 1 | Odd half dirty (writable) |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| res_valid | output | 1 | Result registers updated at the last edge |
| res_code | output | 2 | 0 MATCH, 1 NOMATCH, 2 INVALID, 3 MODIFIED |
| res_pa | output | 32 | Translated physical address (MATCH only) |
| res_writable | output | 1 | Selected half's dirty bit on a hit |

## Verification
The entry write port and the lookup path can both act in one cycle, and they can target the same entry. The bench provokes this by raising `wr_en` and `lk_req` on the same clock edge. The write loads a fresh mapping into a still-cleared entry, and the lookup asks for an address inside that new mapping. The result is judged correct only if the lookup in that cycle reports NOMATCH from the old contents, and an identical lookup one cycle later reports MATCH with the new frame address.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  // Lookup outcome encoding seen at the res_code port.
  typedef enum logic [1:0] {
    RES_MATCH    = 2'd0,
    RES_NOMATCH  = 2'd1,
    RES_INVALID  = 2'd2,
    RES_MODIFIED = 2'd3
  } tlbp_res_e;

endpackage

// File: rtl/tlbp_store.sv
module tlbp_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int VPN2_W  = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [VPN2_W-1:0] wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic              wr_v_even,
  input  logic              wr_v_odd,
  input  logic              wr_d_even,
  input  logic              wr_d_odd,
  output logic [VPN2_W-1:0] ent_vpn2   [ENTRIES],
  output logic [VPN2_W-1:0] ent_pmask  [ENTRIES],
  output logic [ASID_W-1:0] ent_asid   [ENTRIES],
  output logic              ent_global [ENTRIES],
  output logic [PFN_W-1:0]  ent_pfn_e  [ENTRIES],
  output logic [PFN_W-1:0]  ent_pfn_o  [ENTRIES],
  output logic              ent_v_e    [ENTRIES],
  output logic              ent_v_o    [ENTRIES],
  output logic              ent_d_e    [ENTRIES],
  output logic              ent_d_o    [ENTRIES]
);

  // Entries are flops: every one is read in parallel by the comparators.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        ent_vpn2[e]   <= '0;
        ent_pmask[e]  <= '0;
        ent_asid[e]   <= '0;
        ent_global[e] <= 1'b0;
        ent_pfn_e[e]  <= '0;
        ent_pfn_o[e]  <= '0;
        ent_v_e[e]    <= 1'b0;
        ent_v_o[e]    <= 1'b0;
        ent_d_e[e]    <= 1'b0;
        ent_d_o[e]    <= 1'b0;
      end
    end else if (wr_en && (32'(wr_idx) < ENTRIES)) begin
      ent_vpn2[wr_idx]   <= wr_vpn2;
      ent_pmask[wr_idx]  <= wr_pmask;
      ent_asid[wr_idx]   <= wr_asid;
      ent_global[wr_idx] <= wr_global;
      ent_pfn_e[wr_idx]  <= wr_pfn_even;
      ent_pfn_o[wr_idx]  <= wr_pfn_odd;
      ent_v_e[wr_idx]    <= wr_v_even;
      ent_v_o[wr_idx]    <= wr_v_odd;
      ent_d_e[wr_idx]    <= wr_d_even;
      ent_d_o[wr_idx]    <= wr_d_odd;
    end
  end

  // An entry not addressed by the write port keeps its contents (R11).
  for (genvar g = 0; g < ENTRIES; g++) begin : g_quiet
    p_entry_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (32'(wr_idx) == g)) |=>
        $stable({ent_vpn2[g], ent_pmask[g], ent_asid[g], ent_global[g],
                  ent_pfn_e[g], ent_pfn_o[g], ent_v_e[g], ent_v_o[g],
                  ent_d_e[g], ent_d_o[g]}));
  end

endmodule

// File: rtl/tlbp_match.sv
module tlbp_match #(
  parameter int ENTRIES = 16,
  parameter int VPN2_W  = 19,
  parameter int ASID_W  = 8
) (
  input  logic [VPN2_W-1:0] va_vpn2,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VPN2_W-1:0] ent_vpn2   [ENTRIES],
  input  logic [VPN2_W-1:0] ent_pmask  [ENTRIES],
  input  logic [ASID_W-1:0] ent_asid   [ENTRIES],
  input  logic              ent_global [ENTRIES],
  output logic [ENTRIES-1:0] hit
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic tag_eq;
    logic owner_ok;
    // Masked bits of the page-pair number take no part in the compare.
    assign tag_eq   = ((va_vpn2 ^ ent_vpn2[g]) & ~ent_pmask[g]) == '0;
    assign owner_ok = ent_global[g] || (ent_asid[g] == cur_asid);
    assign hit[g]   = tag_eq && owner_ok;
  end

endmodule

// File: rtl/tlbp_prio.sv
module tlbp_prio #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0] hit,
  output logic               any_hit,
  output logic [IDX_W-1:0]   hit_idx
);

  // Scan from the top so the lowest hitting index is written last.
  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit[e]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(e);
      end
    end
  end

endmodule

// File: rtl/tlbp_top.sv
module tlbp_top #(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ASID_W     = 8,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN2_W    = VA_W - PAGE_SHIFT - 1,
  localparam int PFN_W     = PA_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [VPN2_W-1:0] wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic              wr_v_even,
  input  logic              wr_v_odd,
  input  logic              wr_d_even,
  input  logic              wr_d_odd,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [PA_W-1:0]   res_pa,
  output logic              res_writable
);
  import tlbp_pkg::*;

  logic [VPN2_W-1:0] ent_vpn2   [ENTRIES];
  logic [VPN2_W-1:0] ent_pmask  [ENTRIES];
  logic [ASID_W-1:0] ent_asid   [ENTRIES];
  logic              ent_global [ENTRIES];
  logic [PFN_W-1:0]  ent_pfn_e  [ENTRIES];
  logic [PFN_W-1:0]  ent_pfn_o  [ENTRIES];
  logic              ent_v_e    [ENTRIES];
  logic              ent_v_o    [ENTRIES];
  logic              ent_d_e    [ENTRIES];
  logic              ent_d_o    [ENTRIES];

  tlbp_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN2_W(VPN2_W),
    .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn2(wr_vpn2), .wr_pmask(wr_pmask), .wr_asid(wr_asid),
    .wr_global(wr_global), .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_v_even(wr_v_even), .wr_v_odd(wr_v_odd),
    .wr_d_even(wr_d_even), .wr_d_odd(wr_d_odd),
    .ent_vpn2(ent_vpn2), .ent_pmask(ent_pmask), .ent_asid(ent_asid),
    .ent_global(ent_global), .ent_pfn_e(ent_pfn_e), .ent_pfn_o(ent_pfn_o),
    .ent_v_e(ent_v_e), .ent_v_o(ent_v_o), .ent_d_e(ent_d_e), .ent_d_o(ent_d_o)
  );

  logic [ENTRIES-1:0] hit;
  logic               any_hit;
  logic [IDX_W-1:0]   hit_idx;

  tlbp_match #(
    .ENTRIES(ENTRIES), .VPN2_W(VPN2_W), .ASID_W(ASID_W)
  ) u_match (
    .va_vpn2(lk_va[VA_W-1:PAGE_SHIFT+1]), .cur_asid(lk_asid),
    .ent_vpn2(ent_vpn2), .ent_pmask(ent_pmask), .ent_asid(ent_asid),
    .ent_global(ent_global), .hit(hit)
  );

  tlbp_prio #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_prio (
    .hit(hit), .any_hit(any_hit), .hit_idx(hit_idx)
  );

  // Selected entry, half choice and permission decode.
  logic [VA_W-1:0]   eff_mask;
  logic [VA_W-1:0]   half_mask;
  logic              odd_sel;
  logic              sel_v;
  logic              sel_d;
  logic [PFN_W-1:0]  sel_pfn;
  tlbp_res_e         code_n;
  logic [PA_W-1:0]   pa_n;

  always_comb begin
    eff_mask  = {ent_pmask[hit_idx], {(PAGE_SHIFT + 1){1'b1}}};
    half_mask = eff_mask >> 1;
    odd_sel   = |(lk_va & eff_mask & ~half_mask);
    sel_v     = odd_sel ? ent_v_o[hit_idx]   : ent_v_e[hit_idx];
    sel_d     = odd_sel ? ent_d_o[hit_idx]   : ent_d_e[hit_idx];
    sel_pfn   = odd_sel ? ent_pfn_o[hit_idx] : ent_pfn_e[hit_idx];
    if (!any_hit)
      code_n = RES_NOMATCH;
    else if (!sel_v)
      code_n = RES_INVALID;
    else if (lk_write && !sel_d)
      code_n = RES_MODIFIED;
    else
      code_n = RES_MATCH;
    pa_n = '0;
    if (code_n == RES_MATCH)
      pa_n = {sel_pfn, {PAGE_SHIFT{1'b0}}} | PA_W'(lk_va & half_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_code     <= RES_NOMATCH;
      res_pa       <= '0;
      res_writable <= 1'b0;
    end else begin
      res_valid <= lk_req;
      if (lk_req) begin
        res_code     <= code_n;
        res_pa       <= pa_n;
        res_writable <= any_hit && sel_d;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> res_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> (!res_valid && $stable(res_code) && $stable(res_pa)
                 && $stable(res_writable)));

  p_nomatch_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == RES_NOMATCH) |-> (!res_writable && res_pa == '0));

  p_modified_store_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == RES_MODIFIED) |-> (!res_writable && $past(lk_write)));

  p_store_match_dirty_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == RES_MATCH && $past(lk_write)) |-> res_writable);

  p_lowest_wins_r10: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (hit[hit_idx] &&
                 ((hit & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0)));

endmodule

// File: tb/tb_tlbp_top.sv
`timescale 1ns/1ps
module tb_tlbp_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [18:0] wr_vpn2;
  logic [18:0] wr_pmask;
  logic [7:0]  wr_asid;
  logic        wr_global;
  logic [19:0] wr_pfn_even;
  logic [19:0] wr_pfn_odd;
  logic        wr_v_even, wr_v_odd, wr_d_even, wr_d_odd;
  logic        lk_req;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        lk_write;
  logic        res_valid;
  logic [1:0]  res_code;
  logic [31:0] res_pa;
  logic        res_writable;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [1:0] C_MATCH = 2'd0, C_NOMATCH = 2'd1,
                         C_INVALID = 2'd2, C_MODIFIED = 2'd3;

  always #2.5 clk = ~clk;

  tlbp_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn2(wr_vpn2), .wr_pmask(wr_pmask), .wr_asid(wr_asid),
    .wr_global(wr_global), .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_v_even(wr_v_even), .wr_v_odd(wr_v_odd),
    .wr_d_even(wr_d_even), .wr_d_odd(wr_d_odd),
    .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
    .res_valid(res_valid), .res_code(res_code), .res_pa(res_pa),
    .res_writable(res_writable)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ent(input int idx, input logic [18:0] vpn2,
                        input logic [18:0] pmask, input logic [7:0] asid,
                        input logic g, input logic [19:0] pe, input logic [19:0] po,
                        input logic ve, input logic vo, input logic de, input logic dod);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn2 = vpn2; wr_pmask = pmask;
    wr_asid = asid; wr_global = g; wr_pfn_even = pe; wr_pfn_odd = po;
    wr_v_even = ve; wr_v_odd = vo; wr_d_even = de; wr_d_odd = dod;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Drive at a falling edge; the result is registered at the next rising
  // edge and sampled at the following falling edge.
  task automatic look(input string req, input logic [31:0] va,
                      input logic [7:0] asid, input logic w,
                      input logic [1:0] ecode, input logic [31:0] epa,
                      input logic ew);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va; lk_asid = asid; lk_write = w;
    @(negedge clk);
    lk_req = 1'b0;
    chk(req, "valid", 32'(res_valid), 32'd1);
    chk(req, "code", 32'(res_code), 32'(ecode));
    chk(req, "pa", res_pa, epa);
    chk(req, "writable", 32'(res_writable), 32'(ew));
  endtask

  task automatic t_reset;
    // R12: outputs after reset, then a miss with non-zero ASID
    chk("R12", "valid after reset", 32'(res_valid), 32'd0);
    chk("R12", "code after reset", 32'(res_code), 32'(C_NOMATCH));
    look("R12", 32'h0002_0000, 8'd1, 1'b0, C_NOMATCH, 32'h0, 1'b0);
  endtask

  task automatic t_basic;
    // entry 0: pair at 0x00020000, ASID 5, even dirty, odd clean
    wr_ent(0, 19'h10, 19'h0, 8'd5, 1'b0, 20'h11111, 20'h22222, 1, 1, 1, 0);
    look("R7", 32'h0002_0ABC, 8'd5, 1'b0, C_MATCH, 32'h1111_1ABC, 1'b1);
    look("R4", 32'h0002_1ABC, 8'd5, 1'b0, C_MATCH, 32'h2222_2ABC, 1'b0);
    look("R6", 32'h0002_1ABC, 8'd5, 1'b1, C_MODIFIED, 32'h0, 1'b0);
    look("R6", 32'h0002_0ABC, 8'd5, 1'b1, C_MATCH, 32'h1111_1ABC, 1'b1);
    look("R2", 32'h0002_0ABC, 8'd6, 1'b0, C_NOMATCH, 32'h0, 1'b0);
    look("R8", 32'h0002_2000, 8'd5, 1'b0, C_NOMATCH, 32'h0, 1'b0);
  endtask

  task automatic t_global_invalid;
    // entry 1: global, even half invalid but dirty, odd valid and dirty
    wr_ent(1, 19'h100, 19'h0, 8'd9, 1'b1, 20'h00001, 20'h33333, 0, 1, 1, 1);
    look("R5", 32'h0020_0123, 8'd3, 1'b0, C_INVALID, 32'h0, 1'b1);
    look("R9", 32'h0020_1123, 8'd3, 1'b1, C_MATCH, 32'h3333_3123, 1'b1);
  endtask

  task automatic t_mask;
    // entry 2: mask 3 -> 16 KB halves, select bit is address bit 14
    wr_ent(2, 19'h400, 19'h3, 8'd5, 1'b0, 20'h40000, 20'h50000, 1, 1, 1, 1);
    look("R3", 32'h0080_3456, 8'd5, 1'b0, C_MATCH, 32'h4000_3456, 1'b1);
    look("R4", 32'h0080_5456, 8'd5, 1'b0, C_MATCH, 32'h5000_1456, 1'b1);
    look("R7", 32'h0080_6000, 8'd5, 1'b1, C_MATCH, 32'h5000_2000, 1'b1);
    look("R3", 32'h0080_8000, 8'd5, 1'b0, C_NOMATCH, 32'h0, 1'b0);
  endtask

  task automatic t_priority;
    // entries 3 and 7 claim the same global pair
    wr_ent(7, 19'h800, 19'h0, 8'd0, 1'b1, 20'h0BBBB, 20'h0BBBB, 1, 1, 1, 1);
    wr_ent(3, 19'h800, 19'h0, 8'd0, 1'b1, 20'h0AAAA, 20'h0AAAA, 1, 1, 1, 1);
    look("R10", 32'h0100_0044, 8'd2, 1'b0, C_MATCH, 32'h0AAA_A044, 1'b1);
    wr_ent(3, 19'h800, 19'h0, 8'd0, 1'b1, 20'h0AAAA, 20'h0AAAA, 0, 1, 1, 1);
    look("R10", 32'h0100_0044, 8'd2, 1'b0, C_INVALID, 32'h0, 1'b1);
  endtask

  task automatic t_same_cycle;
    // R11: write entry 4 and look it up at the same edge
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd4; wr_vpn2 = 19'h1000; wr_pmask = 19'h0;
    wr_asid = 8'd5; wr_global = 1'b0; wr_pfn_even = 20'h77777;
    wr_pfn_odd = 20'h66666; wr_v_even = 1; wr_v_odd = 1; wr_d_even = 1;
    wr_d_odd = 1;
    lk_req = 1'b1; lk_va = 32'h0200_0010; lk_asid = 8'd5; lk_write = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    chk("R11", "same-cycle code", 32'(res_code), 32'(C_NOMATCH));
    look("R11", 32'h0200_0010, 8'd5, 1'b0, C_MATCH, 32'h7777_7010, 1'b1);
  endtask

  task automatic t_hold;
    // R1: after a lookup, an idle cycle keeps results and drops valid
    look("R1", 32'h0002_0ABC, 8'd5, 1'b0, C_MATCH, 32'h1111_1ABC, 1'b1);
    @(negedge clk);
    lk_va = 32'h0; lk_asid = 8'd77; lk_write = 1'b1;
    @(negedge clk);
    chk("R1", "valid idle", 32'(res_valid), 32'd0);
    chk("R1", "code held", 32'(res_code), 32'(C_MATCH));
    chk("R1", "pa held", res_pa, 32'h1111_1ABC);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_vpn2 = '0; wr_pmask = '0;
    wr_asid = '0; wr_global = 1'b0; wr_pfn_even = '0; wr_pfn_odd = '0;
    wr_v_even = 1'b0; wr_v_odd = 1'b0; wr_d_even = 1'b0; wr_d_odd = 1'b0;
    lk_req = 1'b0; lk_va = '0; lk_asid = '0; lk_write = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_global_invalid();
    t_mask();
    t_priority();
    t_same_cycle();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule